// File: doc/BRIEF.md
# Interleaved Horner Polynomial Waveform Engine

This block generates several independent periodic waveforms by evaluating a piecewise fifth-order polynomial of each channel's phase. Each channel has its own phase accumulator and frequency word. The upper phase bits pick one of the polynomial segments. The next bits form an unsigned fractional argument. Horner's rule is evaluated on one shared pipelined multiplier, with coefficients fetched through a single read port of a coefficient memory.

The latency of the multiplier pipeline equals the channel count. The channels are visited in a fixed rotation, one per clock, so a channel's product leaves the pipeline in the same cycle that the channel comes round again. That product is rounded, the next coefficient is added and saturated, and the result goes straight back into the multiplier. No accumulator is stored per channel, and no pipeline slot stays idle. After the last pass the channel emits one sample with a valid strobe and its channel number. It then advances its phase, optionally adding a small pseudo-random dither to the argument of the next sample.

A host loads coefficients and frequency words through two simple write ports. Both kinds of setting survive reset, so they can be loaded while reset is held and a run can then be started cleanly.

Top module: `hornerWaveEngine`

## Requirements
- R1: While reset is held and in the cycle after it, `sampleValid` is 0. After reset, `sampleChan` and `sampleData` read 0 and every phase accumulator restarts from zero.
- R2: With dither off, each sample equals acc := c5, then five passes acc := sat(round(acc·x) + ck) for k = 4, 3, 2, 1, 0. Coefficients are 18-bit two's complement values with 16 fraction bits. x is an 18-bit value with 17 fraction bits. round(p) = (p + 2^16) >> 17, using an arithmetic shift.
- R3: For an evaluation phase P of 24 bits, the segment is P[23:20] and x = {0, P[19:3]}. Coefficient ck of segment s is stored at memory address {s[3:0], k[2:0]}. Addresses with k = 6 or 7 are never read.
- R4: Every pass saturates its sum to the range [-131072, 131071].
- R5: Samples leave in rotation order 0, 1, 2, 3, 0, … on `sampleChan`. A given channel produces a sample exactly every 24 cycles.
- R6: The first sample (channel 0) is visible in the 22nd cycle after the first clock edge at which reset is low.
- R7: With dither off, sample n of a channel is evaluated at phase n·F mod 2^24, where F is that channel's frequency word.
- R8: When `ditherEn` is 1, the dither is the low 4 bits of a 16-bit LFSR. The LFSR is seeded with 0xACE1 on reset and steps once per emitted sample: shift right, and XOR with 0xB400 when the bit shifted out was 1. Its value before each step is added to the channel's new phase to form the evaluation phase of that channel's next sample.
- R9: Coefficient and frequency writes are accepted while reset is held, and reset does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 7 | Coefficient address {segment, k} |
| coefData | input | 18 | Coefficient value, signed |
| freqWe | input | 1 | Frequency word write strobe |
| freqChan | input | 2 | Channel whose frequency word is written |
| freqWord | input | 24 | Phase increment per sample |
| ditherEn | input | 1 | Adds LFSR dither to the evaluation phase |
| sampleValid | output | 1 | One-cycle strobe for a new sample |
| sampleChan | output | 2 | Channel number of the sample |
| sampleData | output | 18 | Sample value, signed |

## Verification
The assertions assume that reset is held for at least one clock and that configuration writes happen only while reset is held, because a write in mid-run could collide with an in-flight coefficient fetch or change a frequency word between two samples. They also assume that `ditherEn` stays constant during a run. The stimulus keeps to these assumptions: every coefficient and frequency word is written inside a reset window, and the dither setting changes only across a reset. The bench keeps its own phase and LFSR model per channel and compares each sample arithmetically. Its frequency words are chosen so that one channel walks through all segments at x = 0 and two others land on the outermost argument of the two saturating segments.

// File: rtl/hornerPkg.sv
package hornerPkg;

  // Per-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic load;    // current channel starts a sample: accumulator = top coefficient
    logic issue;   // current accumulator value enters the multiplier
    logic finish;  // current pass is the last one: emit sample, advance phase
  } hornerStrobe_t;

endpackage

// File: rtl/hornerCtrl.sv
module hornerCtrl
  import hornerPkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ORDER  = 5,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int STEP_W = $clog2(ORDER + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output hornerStrobe_t     strobe,
  output logic [CH_W-1:0]   curChan,
  output logic [CH_W-1:0]   nextChan,
  output logic [STEP_W-1:0] nextK
);

  logic [CH_W-1:0]   slot;
  logic              warm;
  logic [STEP_W-1:0] stepCnt [NUM_CH];
  logic [STEP_W-1:0] curStep;

  always_comb begin
    nextChan      = (slot == CH_W'(NUM_CH - 1)) ? '0 : slot + 1'b1;
    nextK         = STEP_W'(ORDER) - stepCnt[nextChan];
    curStep       = stepCnt[slot];
    curChan       = slot;
    strobe.load   = warm && (curStep == '0);
    strobe.issue  = warm && (curStep != STEP_W'(ORDER));
    strobe.finish = warm && (curStep == STEP_W'(ORDER));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= CH_W'(NUM_CH - 1);
      warm <= 1'b0;
    end else begin
      slot <= nextChan;
      warm <= 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_step
    always_ff @(posedge clk) begin
      if (rst) begin
        stepCnt[c] <= '0;
      end else if (warm && slot == CH_W'(c)) begin
        stepCnt[c] <= (curStep == STEP_W'(ORDER)) ? '0 : curStep + 1'b1;
      end
    end
  end

endmodule

// File: rtl/pipeMul.sv
module pipeMul #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int LAT = 4,
  localparam int P_W = A_W + B_W
) (
  input  logic                  clk,
  input  logic signed [A_W-1:0] opA,
  input  logic signed [B_W-1:0] opB,
  output logic signed [P_W-1:0] prod
);

  logic signed [A_W-1:0] aQ;
  logic signed [B_W-1:0] bQ;
  logic signed [P_W-1:0] stage [LAT-1];

  always_ff @(posedge clk) begin
    aQ       <= opA;
    bQ       <= opB;
    stage[0] <= aQ * bQ;
  end

  for (genvar i = 1; i < LAT - 1; i++) begin : g_stage
    always_ff @(posedge clk) stage[i] <= stage[i-1];
  end

  assign prod = stage[LAT-2];

endmodule

// File: rtl/coefRam.sv
module coefRam #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 7,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wAddr,
  input  logic [DATA_W-1:0] wData,
  input  logic [ADDR_W-1:0] rAddr,
  output logic [DATA_W-1:0] rData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end

endmodule

// File: rtl/hornerDatapath.sv
module hornerDatapath
  import hornerPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ORDER     = 5,
  parameter int DATA_W    = 18,
  parameter int PHASE_W   = 24,
  parameter int SEG_BITS  = 4,
  parameter int DITH_BITS = 4,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int STEP_W  = $clog2(ORDER + 1),
  localparam int COEF_AW = SEG_BITS + STEP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  hornerStrobe_t      strobe,
  input  logic [CH_W-1:0]    curChan,
  input  logic [CH_W-1:0]    nextChan,
  input  logic [STEP_W-1:0]  nextK,
  input  logic               coefWe,
  input  logic [COEF_AW-1:0] coefAddr,
  input  logic [DATA_W-1:0]  coefData,
  input  logic               freqWe,
  input  logic [CH_W-1:0]    freqChan,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               ditherEn,
  output logic               sampleValid,
  output logic [CH_W-1:0]    sampleChan,
  output logic [DATA_W-1:0]  sampleData
);

  localparam int FRAC_X = DATA_W - 1;
  localparam int PROD_W = 2 * DATA_W;
  localparam int SUM_W  = DATA_W + 2;
  localparam int X_TOP  = PHASE_W - SEG_BITS - 1;
  localparam logic signed [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (FRAC_X - 1);
  localparam logic signed [SUM_W-1:0]  SAT_HI   = SUM_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0]  SAT_LO   = -SAT_HI - 1;

  logic [PHASE_W-1:0]       freqReg  [NUM_CH];
  logic [PHASE_W-1:0]       phaseReg [NUM_CH];
  logic [SEG_BITS-1:0]      segReg   [NUM_CH];
  logic signed [DATA_W-1:0] xReg     [NUM_CH];
  logic [LFSR_W-1:0]        lfsr;

  logic [DATA_W-1:0]        ramQ;
  logic signed [DATA_W-1:0] coefQ;
  logic signed [PROD_W-1:0] mulOut;
  logic signed [PROD_W-1:0] roundFull;
  logic signed [SUM_W-1:0]  sumWide;
  logic signed [DATA_W-1:0] satSum;
  logic signed [DATA_W-1:0] newAcc;
  logic signed [DATA_W-1:0] mulA;
  logic signed [DATA_W-1:0] mulB;
  logic [PHASE_W-1:0]       phaseNext;
  logic [PHASE_W-1:0]       dithTerm;
  logic [PHASE_W-1:0]       evalNext;
  logic [LFSR_W-1:0]        lfsrNext;
  logic [COEF_AW-1:0]       rdAddr;

  // Coefficient fetch runs one cycle ahead of the channel that will use it.
  assign rdAddr = {segReg[nextChan], nextK};

  coefRam #(
    .DATA_W (DATA_W),
    .ADDR_W (COEF_AW)
  ) u_ram (
    .clk   (clk),
    .we    (coefWe),
    .wAddr (coefAddr),
    .wData (coefData),
    .rAddr (rdAddr),
    .rData (ramQ)
  );

  pipeMul #(
    .A_W (DATA_W),
    .B_W (DATA_W),
    .LAT (NUM_CH)
  ) u_mul (
    .clk  (clk),
    .opA  (mulA),
    .opB  (mulB),
    .prod (mulOut)
  );

  always_comb begin
    coefQ     = $signed(ramQ);
    roundFull = (mulOut + HALF_LSB) >>> FRAC_X;
    sumWide   = $signed(roundFull[SUM_W-1:0])
              + $signed({{(SUM_W - DATA_W){coefQ[DATA_W-1]}}, coefQ});
    if (sumWide > SAT_HI)      satSum = $signed(SAT_HI[DATA_W-1:0]);
    else if (sumWide < SAT_LO) satSum = $signed(SAT_LO[DATA_W-1:0]);
    else                       satSum = $signed(sumWide[DATA_W-1:0]);
    newAcc    = strobe.load ? coefQ : satSum;
    mulA      = strobe.issue ? newAcc : '0;
    mulB      = xReg[curChan];
    phaseNext = phaseReg[curChan] + freqReg[curChan];
    dithTerm  = ditherEn ? PHASE_W'(lfsr[DITH_BITS-1:0]) : '0;
    evalNext  = phaseNext + dithTerm;
    lfsrNext  = {1'b0, lfsr[LFSR_W-1:1]} ^ (lfsr[0] ? LFSR_TAPS : '0);
  end

  // Frequency words are configuration: written by the host, kept across reset.
  always_ff @(posedge clk) begin
    if (freqWe) freqReg[freqChan] <= freqWord;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NUM_CH; c++) begin
        phaseReg[c] <= '0;
        segReg[c]   <= '0;
        xReg[c]     <= '0;
      end
      lfsr        <= LFSR_SEED;
      sampleValid <= 1'b0;
      sampleChan  <= '0;
      sampleData  <= '0;
    end else begin
      sampleValid <= strobe.finish;
      if (strobe.finish) begin
        sampleChan         <= curChan;
        sampleData         <= satSum;
        phaseReg[curChan]  <= phaseNext;
        segReg[curChan]    <= evalNext[PHASE_W-1 -: SEG_BITS];
        xReg[curChan]      <= $signed({1'b0, evalNext[X_TOP -: FRAC_X]});
        lfsr               <= lfsrNext;
      end
    end
  end

endmodule

// File: rtl/hornerWaveEngine.sv
module hornerWaveEngine
  import hornerPkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int ORDER     = 5,
  parameter int DATA_W    = 18,
  parameter int PHASE_W   = 24,
  parameter int SEG_BITS  = 4,
  parameter int DITH_BITS = 4,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int STEP_W  = $clog2(ORDER + 1),
  localparam int COEF_AW = SEG_BITS + STEP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               coefWe,
  input  logic [COEF_AW-1:0] coefAddr,
  input  logic [DATA_W-1:0]  coefData,
  input  logic               freqWe,
  input  logic [CH_W-1:0]    freqChan,
  input  logic [PHASE_W-1:0] freqWord,
  input  logic               ditherEn,
  output logic               sampleValid,
  output logic [CH_W-1:0]    sampleChan,
  output logic [DATA_W-1:0]  sampleData
);

  hornerStrobe_t     strobe;
  logic [CH_W-1:0]   curChan;
  logic [CH_W-1:0]   nextChan;
  logic [STEP_W-1:0] nextK;

  hornerCtrl #(
    .NUM_CH (NUM_CH),
    .ORDER  (ORDER)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curChan  (curChan),
    .nextChan (nextChan),
    .nextK    (nextK)
  );

  hornerDatapath #(
    .NUM_CH    (NUM_CH),
    .ORDER     (ORDER),
    .DATA_W    (DATA_W),
    .PHASE_W   (PHASE_W),
    .SEG_BITS  (SEG_BITS),
    .DITH_BITS (DITH_BITS)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .curChan     (curChan),
    .nextChan    (nextChan),
    .nextK       (nextK),
    .coefWe      (coefWe),
    .coefAddr    (coefAddr),
    .coefData    (coefData),
    .freqWe      (freqWe),
    .freqChan    (freqChan),
    .freqWord    (freqWord),
    .ditherEn    (ditherEn),
    .sampleValid (sampleValid),
    .sampleChan  (sampleChan),
    .sampleData  (sampleData)
  );

endmodule

// File: rtl/hornerChecker.sv
module hornerChecker #(
  parameter int NUM_CH = 4,
  parameter int ORDER  = 5,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic            clk,
  input logic            rst,
  input logic            sampleValid,
  input logic [CH_W-1:0] sampleChan
);

  localparam int FIRST_LAT = NUM_CH * ORDER + 2;
  localparam int PERIOD    = (ORDER + 1) * NUM_CH;

  logic [15:0]     sinceRst;
  logic [15:0]     gap0;
  logic            seenAny;
  logic            seen0;
  logic [CH_W-1:0] lastChan;
  logic [CH_W-1:0] expectChan;

  assign expectChan = (lastChan == CH_W'(NUM_CH - 1)) ? '0 : lastChan + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sinceRst <= '0;
      gap0     <= '0;
      seenAny  <= 1'b0;
      seen0    <= 1'b0;
      lastChan <= '0;
    end else begin
      if (sinceRst != '1) sinceRst <= sinceRst + 1'b1;
      if (sampleValid && sampleChan == '0) begin
        gap0  <= 16'd1;
        seen0 <= 1'b1;
      end else if (gap0 != '1) begin
        gap0 <= gap0 + 1'b1;
      end
      if (sampleValid) begin
        seenAny  <= 1'b1;
        lastChan <= sampleChan;
      end
    end
  end

  // R1: reset silences the sample strobe in the following cycle
  p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !sampleValid);

  // R6: first sample after reset arrives at a fixed cycle
  p_first_latency_r6: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && !seenAny) |-> (sinceRst == 16'(FIRST_LAT)));

  // R5: channel tags follow the rotation
  p_round_robin_r5: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && seenAny) |-> (sampleChan == expectChan));

  // R5: channel 0 produces a sample once per full period
  p_cadence_r5: assert property (@(posedge clk) disable iff (rst)
    (sampleValid && sampleChan == '0 && seen0) |-> (gap0 == 16'(PERIOD)));

endmodule

bind hornerWaveEngine hornerChecker #(
  .NUM_CH (NUM_CH),
  .ORDER  (ORDER)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .sampleChan  (sampleChan)
);

// File: tb/sim_hornerWaveEngine.sv
`timescale 1ns/1ps
module sim_hornerWaveEngine;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        coefWe = 1'b0;
  logic [6:0]  coefAddr = '0;
  logic [17:0] coefData = '0;
  logic        freqWe = 1'b0;
  logic [1:0]  freqChan = '0;
  logic [23:0] freqWord = '0;
  logic        ditherEn = 1'b0;
  logic        sampleValid;
  logic [1:0]  sampleChan;
  logic [17:0] sampleData;

  int checks = 0;
  int fails  = 0;
  int satHits = 0;
  int cycles = 0;
  logic [23:0] freqB [NCH];

  always #4 clk = ~clk;

  hornerWaveEngine u0 (
    .clk (clk), .rst (rst),
    .coefWe (coefWe), .coefAddr (coefAddr), .coefData (coefData),
    .freqWe (freqWe), .freqChan (freqChan), .freqWord (freqWord),
    .ditherEn (ditherEn),
    .sampleValid (sampleValid), .sampleChan (sampleChan), .sampleData (sampleData)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint coefModel(input int seg, input int k);
    int h;
    logic signed [15:0] t;
    if (seg == 15) return longint'(131071 - k * 3);
    if (seg == 14) return longint'(-131072 + k * 5);
    h = (seg * 37 + k * 11 + 5) * 40503;
    h = h ^ (h >>> 7);
    t = h[15:0];
    return longint'(t);
  endfunction

  function automatic longint evalModel(input logic [23:0] ph, output bit sat);
    int seg;
    longint x, acc, p, r, s;
    seg = int'(ph[23:20]);
    x   = longint'(ph[19:3]);
    sat = 1'b0;
    acc = coefModel(seg, 5);
    for (int k = 4; k >= 0; k--) begin
      p = acc * x;
      r = (p + 65536) >>> 17;
      s = r + coefModel(seg, k);
      if (s > 131071) begin s = 131071; sat = 1'b1; end
      else if (s < -131072) begin s = -131072; sat = 1'b1; end
      acc = s;
    end
    return acc;
  endfunction

  // runIdx 0: plain run, 1: dither, 2: plain run after mid-stream reset
  task automatic runPhase(input int runIdx, input int perCh);
    logic [23:0] phaseB [NCH];
    logic [23:0] evalB [NCH];
    int idx [NCH];
    logic [15:0] lfsrB;
    int got, cyc, lastCh0, c;
    bit first, sat, dith;
    int lastChan;
    longint expV, actV;
    string tag;
    dith = (runIdx == 1);
    @(negedge clk);
    rst = 1'b1;
    ditherEn = dith;
    @(negedge clk);
    check(sampleValid == 1'b0, "R1 valid low in reset", longint'(sampleValid), 0);
    repeat (2) @(negedge clk);
    check(sampleValid == 1'b0, "R1 valid", longint'(sampleValid), 0);
    check(sampleChan == 2'd0, "R1 chan", longint'(sampleChan), 0);
    check(sampleData == 18'd0, "R1 data", longint'(sampleData), 0);
    for (int i = 0; i < NCH; i++) begin
      phaseB[i] = '0; evalB[i] = '0; idx[i] = 0;
    end
    lfsrB = 16'hACE1;
    got = 0; cyc = 0; lastCh0 = 0; first = 1'b1; lastChan = NCH - 1;
    rst = 1'b0;
    while (got < perCh * NCH) begin
      @(negedge clk);
      cyc++;
      if (sampleValid) begin
        c = int'(sampleChan);
        if (first) begin
          check(cyc == 22, "R6 first sample cycle", cyc, 22);
          first = 1'b0;
        end else begin
          check(c == (lastChan + 1) % NCH, "R5 rotation", c, (lastChan + 1) % NCH);
        end
        if (c == 0) begin
          if (idx[0] > 0) check(cyc - lastCh0 == 24, "R5 period", cyc - lastCh0, 24);
          lastCh0 = cyc;
        end
        lastChan = c;
        expV = evalModel(evalB[c], sat);
        actV = longint'($signed(sampleData));
        if (sat) satHits++;
        if (runIdx == 1)      tag = "R8 dithered sample";
        else if (runIdx == 2) tag = "R9 retained config";
        else if (sat)         tag = "R4 saturated sample";
        else if (c == 0)      tag = "R3 segment walk";
        else if (c == 2)      tag = "R7 phase advance";
        else                  tag = "R2 horner sample";
        check(actV == expV, tag, actV, expV);
        phaseB[c] = phaseB[c] + freqB[c];
        evalB[c]  = phaseB[c] + (dith ? {20'd0, lfsrB[3:0]} : 24'd0);
        lfsrB     = {1'b0, lfsrB[15:1]} ^ (lfsrB[0] ? 16'hB400 : 16'h0000);
        idx[c]++;
        got++;
      end
    end
  endtask

  initial begin
    freqB[0] = 24'h100000;  // one segment per sample, x = 0
    freqB[1] = 24'hEFFFF0;  // lands on segment 14 near x = 1
    freqB[2] = 24'h7A5A5B;
    freqB[3] = 24'hFFFFFF;  // lands on segment 15 at largest x
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R9: all configuration written while reset is held
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        coefWe   = 1'b1;
        coefAddr = 7'(s * 8 + k);
        coefData = 18'(coefModel(s, k));
      end
    end
    @(negedge clk);
    coefWe = 1'b0;
    for (int ch = 0; ch < NCH; ch++) begin
      @(negedge clk);
      freqWe   = 1'b1;
      freqChan = 2'(ch);
      freqWord = freqB[ch];
    end
    @(negedge clk);
    freqWe = 1'b0;

    runPhase(0, 20);
    check(satHits > 0, "R4 saturation exercised", satHits, 1);
    runPhase(1, 20);
    runPhase(2, 12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        checks++;
        fails++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cycles, 50000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

endmodule